// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM interface. It samples the row strobe, the column strobe and the write strobe, all active low, in a fast system clock domain. It works out what kind of cycle each row-strobe-low period was by looking at the order in which the strobe edges arrived. No command code is involved. The type is decided from whether the column strobe was already low when the row strobe fell, whether the write strobe was low at that moment, and where write and column edges fell inside the period. When the row strobe returns high, the block reports the cycle type, the row that was opened and the number of column accesses, all marked by a one-clock valid pulse.

The block keeps its own refresh row counter. Refresh cycles that carry no row address take their row from this counter, and the counter steps forward once each such cycle ends. The block also tracks a sticky test-mode flag and flags long refreshes as self refresh. It drives a read-enable signal that shows when a data output would be driven. It can act as a protocol monitor or as the front end of a DRAM emulator. The bench runs it with its default parameters: 12-bit row and counter, 4-bit column count, and a self-refresh threshold of 10000 clocks.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `valid_o`, `read_en_o`, `test_mode_o` and `self_ref_o` are 0, and the refresh row counter is 0, so the first counter-addressed refresh reports row 0.
- R2: Each row-strobe-low period produces exactly one `valid_o` pulse, one clock wide, a few clocks after the row strobe rises. `cycle_o` codes are: 0 read, 1 early write, 2 read-modify-write, 3 row-only refresh, 4 column-before-row refresh, 5 hidden refresh, 6 test-mode entry.
- R3: If the column strobe is low and the write strobe is high when the row strobe falls, the cycle is code 4. Its `row_o` is the counter value, and the counter increments after the cycle.
- R4: If the column and write strobes are both low when the row strobe falls, and the column strobe was not held from a previous access, the cycle is code 6. `row_o` is the counter value and the counter does not change. `test_mode_o` rises with the valid pulse and stays high until a code 3 or code 4 cycle completes.
- R5: If the row strobe falls with the column strobe high and the column strobe never falls in the period, the cycle is code 3. `row_o` is `addr_i` as it was at the row-strobe fall.
- R6: If the write strobe is low at the first column-strobe fall of an access, the cycle is code 1, and `read_en_o` stays 0 while that column access lasts.
- R7: If the write strobe falls while the column strobe is low, after at least one column-strobe fall in an access, the cycle is code 2.
- R8: An access with at least one column-strobe fall that matches neither R6 nor R7 is code 0. `read_en_o` is 1 while the column strobe is low in such an access.
- R9: Suppose an access ends with the column strobe still low, and the row strobe falls again before the column strobe rises. That second period is code 5, with `row_o` taken from the counter, and the counter increments.
- R10: `self_ref_o` is 1 with the valid pulse of a code 4 cycle whose row strobe stayed low for at least SELF_CYC clocks, and 0 for any shorter cycle.
- R11: `col_cnt_o` is the number of column-strobe falls in the period, saturating at 2^CNT_W-1.
- R12: The refresh counter wraps from 2^ROW_W-1 to 0.

Because the strobes cross clock domains, the column and write edges must be at least one clock apart from each other and from the row edges to be resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low, asynchronous |
| cas_ni | input | 1 | Column strobe, active low, asynchronous |
| we_ni | input | 1 | Write strobe, active low, asynchronous |
| addr_i | input | ROW_W | Multiplexed address pins, held stable around the row-strobe fall |
| valid_o | output | 1 | One-clock pulse marking a completed period |
| cycle_o | output | 3 | Cycle type code, valid with `valid_o` |
| row_o | output | ROW_W | Row opened or refreshed in the period |
| col_cnt_o | output | CNT_W | Column accesses in the period |
| self_ref_o | output | 1 | Period was a self refresh |
| test_mode_o | output | 1 | Sticky test-mode flag |
| read_en_o | output | 1 | Data output would be driven |

## Verification
A refresh counter that drifts, skips or fails to wrap shows up as a wrong `row_o` on the very next counter-addressed refresh. The bench tracks the counter on its own and checks every such cycle, including a full lap of 4096 refreshes. A lost record of a held column strobe turns a hidden refresh into a code 4 or code 6 report in that same period. A wrong early-write capture shows up on `read_en_o` within four clocks of the column-strobe fall, before the period ends. A duplicated or missing valid pulse shows up in a running pulse count that is compared against the number of periods driven.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CYC_READ   = 3'd0,
    CYC_EWRITE = 3'd1,
    CYC_RMW    = 3'd2,
    CYC_RONLY  = 3'd3,
    CYC_CBR    = 3'd4,
    CYC_HIDDEN = 3'd5,
    CYC_TEST   = 3'd6
  } cyc_e;

  typedef enum logic [1:0] {
    M_ACC  = 2'd0,
    M_CBR  = 2'd1,
    M_HID  = 2'd2,
    M_TEST = 2'd3
  } mode_e;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign fall_o[g] = s3_q & ~s2_q;
    assign rise_o[g] = ~s3_q & s2_q;
  end
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
  import dcd_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int CNT_W    = 4,
  parameter int SELF_CYC = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_fall_i,
  input  logic             ras_rise_i,
  input  logic             cas_lvl_i,
  input  logic             cas_fall_i,
  input  logic             cas_rise_i,
  input  logic             we_lvl_i,
  input  logic             we_fall_i,
  input  logic [ROW_W-1:0] addr_i,
  input  logic [ROW_W-1:0] ref_row_i,
  output logic             valid_o,
  output logic [2:0]       cycle_o,
  output logic [ROW_W-1:0] row_o,
  output logic [CNT_W-1:0] col_cnt_o,
  output logic             self_ref_o,
  output logic             test_mode_o,
  output logic             read_en_o,
  output logic             ref_inc_o
);
  localparam int LW = $clog2(SELF_CYC + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(SELF_CYC);

  logic             ras_act_q, ew_q, rmw_q, cas_held_q;
  mode_e            mode_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] ccnt_q;
  logic [LW-1:0]    low_q;
  cyc_e             cyc_d;
  logic             acc_open;

  always_comb begin
    unique case (mode_q)
      M_CBR:   cyc_d = CYC_CBR;
      M_HID:   cyc_d = CYC_HIDDEN;
      M_TEST:  cyc_d = CYC_TEST;
      default: cyc_d = (ccnt_q == '0) ? CYC_RONLY :
                       rmw_q ? CYC_RMW : ew_q ? CYC_EWRITE : CYC_READ;
    endcase
  end

  assign acc_open = ras_act_q && !ras_fall_i && !ras_rise_i && (mode_q == M_ACC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_act_q   <= 1'b0;
      mode_q      <= M_ACC;
      row_q       <= '0;
      ccnt_q      <= '0;
      ew_q        <= 1'b0;
      rmw_q       <= 1'b0;
      low_q       <= '0;
      valid_o     <= 1'b0;
      cycle_o     <= 3'd0;
      row_o       <= '0;
      col_cnt_o   <= '0;
      self_ref_o  <= 1'b0;
      test_mode_o <= 1'b0;
      ref_inc_o   <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      ref_inc_o <= 1'b0;
      if (ras_fall_i) begin
        ras_act_q <= 1'b1;
        low_q     <= LW'(1);
        ccnt_q    <= '0;
        ew_q      <= 1'b0;
        rmw_q     <= 1'b0;
        if (!cas_lvl_i) begin
          row_q  <= ref_row_i;
          mode_q <= cas_held_q ? M_HID : (!we_lvl_i ? M_TEST : M_CBR);
        end else begin
          row_q  <= addr_i;
          mode_q <= M_ACC;
        end
      end else if (ras_act_q && ras_rise_i) begin
        ras_act_q  <= 1'b0;
        valid_o    <= 1'b1;
        cycle_o    <= cyc_d;
        row_o      <= row_q;
        col_cnt_o  <= ccnt_q;
        self_ref_o <= (mode_q == M_CBR) && (low_q >= LOW_MAX);
        ref_inc_o  <= (mode_q == M_CBR) || (mode_q == M_HID);
        if (mode_q == M_TEST) test_mode_o <= 1'b1;
        else if (cyc_d == CYC_CBR || cyc_d == CYC_RONLY) test_mode_o <= 1'b0;
      end else if (ras_act_q) begin
        if (low_q < LOW_MAX) low_q <= low_q + 1'b1;
        if (cas_fall_i && mode_q == M_ACC) begin
          if (ccnt_q != '1) ccnt_q <= ccnt_q + 1'b1;
          if (ccnt_q == '0) ew_q <= !we_lvl_i;
        end
        if (we_fall_i && !cas_lvl_i && !cas_fall_i && mode_q == M_ACC && ccnt_q != '0)
          rmw_q <= 1'b1;
      end
    end
  end

  // column strobe held low across the row-strobe rise enables a hidden refresh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cas_held_q <= 1'b0;
    else if (cas_rise_i) cas_held_q <= 1'b0;
    else if (ras_act_q && ras_rise_i && !cas_lvl_i &&
             ((mode_q == M_ACC && ccnt_q != '0) || mode_q == M_HID))
      cas_held_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) read_en_o <= 1'b0;
    else if (cas_rise_i) read_en_o <= 1'b0;
    else if (cas_fall_i && acc_open) read_en_o <= we_lvl_i;
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_W    = 12,
  parameter int CNT_W    = 4,
  parameter int SELF_CYC = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [ROW_W-1:0] addr_i,
  output logic             valid_o,
  output logic [2:0]       cycle_o,
  output logic [ROW_W-1:0] row_o,
  output logic [CNT_W-1:0] col_cnt_o,
  output logic             self_ref_o,
  output logic             test_mode_o,
  output logic             read_en_o
);
  localparam int NSTB = 3;
  localparam int I_WE = 0, I_CAS = 1, I_RAS = 2;

  logic [NSTB-1:0]  lvl, fall, rise;
  logic [ROW_W-1:0] ref_row;
  logic             ref_inc;

  dcd_sync #(.W(NSTB)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ras_ni, cas_ni, we_ni}),
    .lvl_o  (lvl),
    .fall_o (fall),
    .rise_o (rise)
  );

  dcd_refresh_ctr #(.W(ROW_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ref_inc),
    .cnt_o  (ref_row)
  );

  dcd_classifier #(.ROW_W(ROW_W), .CNT_W(CNT_W), .SELF_CYC(SELF_CYC)) u_cls (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ras_fall_i  (fall[I_RAS]),
    .ras_rise_i  (rise[I_RAS]),
    .cas_lvl_i   (lvl[I_CAS]),
    .cas_fall_i  (fall[I_CAS]),
    .cas_rise_i  (rise[I_CAS]),
    .we_lvl_i    (lvl[I_WE]),
    .we_fall_i   (fall[I_WE]),
    .addr_i      (addr_i),
    .ref_row_i   (ref_row),
    .valid_o     (valid_o),
    .cycle_o     (cycle_o),
    .row_o       (row_o),
    .col_cnt_o   (col_cnt_o),
    .self_ref_o  (self_ref_o),
    .test_mode_o (test_mode_o),
    .read_en_o   (read_en_o),
    .ref_inc_o   (ref_inc)
  );
endmodule

// File: rtl/dcd_chk.sv
module dcd_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic [2:0]       cycle_o,
  input logic [ROW_W-1:0] row_o,
  input logic             self_ref_o,
  input logic             test_mode_o,
  input logic [ROW_W-1:0] ref_row_i
);
  logic is_ref;
  assign is_ref = valid_o && (cycle_o == 3'd4 || cycle_o == 3'd5);

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R3
  ref_row_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |-> row_o == ref_row_i);

  // R12
  ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |=> ref_row_i == ROW_W'($past(ref_row_i) + 1'b1));

  // R12
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ref |=> $stable(ref_row_i));

  // R10
  self_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_o && valid_o |-> cycle_o == 3'd4);

  // R4
  test_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode_o) |-> valid_o && cycle_o == 3'd6);
endmodule

bind dram_cycle_decoder dcd_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_o     (valid_o),
  .cycle_o     (cycle_o),
  .row_o       (row_o),
  .self_ref_o  (self_ref_o),
  .test_mode_o (test_mode_o),
  .ref_row_i   (ref_row)
);

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
  localparam int ROW_W = 12;
  localparam int CNT_W = 4;
  localparam int SELF  = 10000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [ROW_W-1:0] addr_i = '0;
  logic valid_o, self_ref_o, test_mode_o, read_en_o;
  logic [2:0] cycle_o;
  logic [ROW_W-1:0] row_o;
  logic [CNT_W-1:0] col_cnt_o;

  int n_chk = 0, n_fail = 0, n_pulse = 0, exp_pulse = 0;
  int exp_ref = 0;
  bit exp_test = 1'b0;
  int c_cyc, c_row, c_cnt, c_self, c_test;

  always #5 clk_i = ~clk_i;

  dram_cycle_decoder #(.ROW_W(ROW_W), .CNT_W(CNT_W), .SELF_CYC(SELF)) dut (.*);

  always @(negedge clk_i) if (rst_ni && valid_o) n_pulse++;

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic int sat_cnt(int n);
    return (n > (1 << CNT_W) - 1) ? (1 << CNT_W) - 1 : n;
  endfunction

  // drive RAS high and wait for the report
  task automatic close_period();
    bit got = 1'b0;
    ras_ni = 1'b1;
    exp_pulse++;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk_i);
      if (valid_o) got = 1'b1;
    end
    check("R2 valid seen", int'(got), 1);
    c_cyc = cycle_o; c_row = row_o; c_cnt = col_cnt_o;
    c_self = self_ref_o; c_test = test_mode_o;
  endtask

  // kind: 0 read, 1 early write first column, 2 rmw on last column
  task automatic access(int row, int ncas, int kind, bit keep_cas);
    int exp_cyc;
    addr_i = ROW_W'(row);
    ras_ni = 1'b0;
    step(4);
    addr_i = ROW_W'($urandom);
    for (int i = 0; i < ncas; i++) begin
      bit wl = (kind == 1 && i == 0);
      we_ni = !wl;
      step(2);
      cas_ni = 1'b0;
      step(4);
      if (wl) check("R6 read_en off in early write", read_en_o, 0);
      else    check("R8 read_en on in read column", read_en_o, 1);
      if (kind == 2 && i == ncas - 1) begin
        we_ni = 1'b0;
        step(3);
      end
      if (!(keep_cas && i == ncas - 1)) cas_ni = 1'b1;
      we_ni = 1'b1;
      step(3);
    end
    close_period();
    exp_cyc = (ncas == 0) ? 3 : (kind == 2) ? 2 : (kind == 1) ? 1 : 0;
    if (ncas == 0) exp_test = 1'b0;
    check(exp_cyc == 3 ? "R5 type" : exp_cyc == 2 ? "R7 type" :
          exp_cyc == 1 ? "R6 type" : "R8 type", c_cyc, exp_cyc);
    check(ncas == 0 ? "R5 row" : "R8 row", c_row, row);
    check("R11 column count", c_cnt, sat_cnt(ncas));
    check("R4 test flag", c_test, int'(exp_test));
    step(3);
  endtask

  task automatic refresh(bit wlow, int hold);
    int ecyc = wlow ? 6 : 4;
    we_ni = !wlow;
    step(2);
    cas_ni = 1'b0;
    step(3);
    ras_ni = 1'b0;
    step(hold);
    close_period();
    cas_ni = 1'b1;
    we_ni = 1'b1;
    check(wlow ? "R4 type" : "R3 type", c_cyc, ecyc);
    check(wlow ? "R4 row" : "R3 row", c_row, exp_ref);
    exp_test = wlow ? 1'b1 : 1'b0;
    check("R4 test flag", c_test, int'(exp_test));
    check("R10 self flag", c_self, int'(!wlow && hold >= SELF + 2));
    if (!wlow) exp_ref = (exp_ref + 1) % (1 << ROW_W);
    step(4);
  endtask

  task automatic hidden();
    access($urandom % (1 << ROW_W), 1, 0, 1'b1);
    check("R8 read_en held", read_en_o, 1);
    ras_ni = 1'b0;
    step(5);
    close_period();
    check("R9 type", c_cyc, 5);
    check("R9 row", c_row, exp_ref);
    exp_ref = (exp_ref + 1) % (1 << ROW_W);
    cas_ni = 1'b1;
    step(4);
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(3);
    check("R1 valid", valid_o, 0);
    check("R1 read_en", read_en_o, 0);
    check("R1 test", test_mode_o, 0);
    check("R1 self", self_ref_o, 0);
    rst_ni = 1'b1;
    step(3);
    refresh(1'b0, 5);                 // R1: first refresh row 0, R3
    access(12'h5a3, 3, 0, 1'b0);      // R8 page read
    access(12'h0ff, 2, 1, 1'b0);      // R6
    access(12'h800, 2, 2, 1'b0);      // R7
    access(12'h321, 0, 0, 1'b0);      // R5
    refresh(1'b1, 5);                 // R4 set
    access(12'h011, 1, 0, 1'b0);      // R4 stays set through a read
    access(12'h012, 0, 0, 1'b0);      // R4 cleared by row-only refresh
    refresh(1'b1, 5);
    refresh(1'b0, 5);                 // R4 cleared by CBR
    access(12'h777, 17, 0, 1'b0);     // R11 saturation
    hidden();                         // R9
    refresh(1'b0, SELF + 20);         // R10 self refresh
    refresh(1'b0, SELF - 20);         // R10 below threshold
    for (int i = 0; i < 40; i++) begin
      int k = $urandom % 6;
      case (k)
        0, 1, 2: access($urandom % (1 << ROW_W), 1 + $urandom % 5, k, 1'b0);
        3:       access($urandom % (1 << ROW_W), 0, 0, 1'b0);
        4:       refresh(bit'($urandom % 2), 4 + $urandom % 6);
        default: hidden();
      endcase
    end
    // R12: full lap of the refresh counter, passing the wrap point
    for (int i = 0; i < (1 << ROW_W); i++) refresh(1'b0, 4);
    check("R2 pulse count", n_pulse, exp_pulse);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule